// File: doc/BRIEF.md
# Radio Register Configuration Sequencer

This block brings an external radio transceiver into a known state by writing a fixed list of register settings over a four-wire serial bus. A single-cycle start pulse launches the sequence. The block then steps through an internal table of eight 24-bit settings. It sends each setting as its own transfer, framed by an active-low select line. When the last transfer has finished, it pulses a done output.

Each setting is an 8-bit address/command byte followed by a 16-bit register value. The bits are sent most significant first. The serial clock idles low and is derived from the system clock by a parameterised divider; the default half-period of 5 cycles gives 10 MHz from a 100 MHz clock. Outgoing data changes only while the serial clock is low, and incoming data is captured on its rising edge. The first byte the radio returns in each transfer is its status. The block keeps the status from the most recent transfer on an output port.

Top module: `radio_cfg_seq`

## Requirements
- R1: While reset is held and just after it is released, bus_sel_n_o is 1, bus_clk_o is 0, cfg_done_o is 0 and radio_status_o is 8'h00.
- R2: A one-cycle cfg_start_i pulse while the block is idle produces exactly 8 transfers. Each transfer is framed by bus_sel_n_o low and contains exactly 24 rising edges of bus_clk_o.
- R3: Transfer k (k = 0..7) carries the 24-bit word {8'h20 + k, 16'hB400 + k*16'h0111}, most significant bit first.
- R4: bus_clk_o stays low whenever bus_sel_n_o is high. Within a transfer, its rising edges are exactly 2*HALF_DIV system clocks apart (100 ns by default).
- R5: bus_dout_o changes only while bus_clk_o is low. bus_din_i is sampled on the rising edge of bus_clk_o.
- R6: Between two consecutive transfers, bus_sel_n_o stays high for at least one serial clock period (2*HALF_DIV system clocks).
- R7: After each transfer, radio_status_o holds the first 8 bits received on bus_din_i in that transfer. At cfg_done_o it shows the status byte from the eighth transfer.
- R8: cfg_done_o is high for exactly one system clock. It rises after bus_sel_n_o has returned high at the end of the eighth transfer.
- R9: A cfg_start_i pulse while a sequence is running is ignored: the sequence still has exactly 8 transfers and no further transfers follow.
- R10: A cfg_start_i pulse in the same cycle that cfg_done_o is high is accepted and starts a new full sequence of 8 transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_i | input | 1 | Single-cycle request to run the configuration sequence |
| cfg_done_o | output | 1 | One-cycle pulse when all settings have been written |
| radio_status_o | output | 8 | Status byte returned by the radio in the latest transfer |
| bus_sel_n_o | output | 1 | Active-low select, low for the whole of each transfer |
| bus_clk_o | output | 1 | Serial clock, idles low |
| bus_dout_o | output | 1 | Serial data to the radio |
| bus_din_i | input | 1 | Serial data from the radio |

## Verification
Two functions can land in the same cycle: the completion pulse of one sequence and the start request of the next. The bench waits until cfg_done_o is high, then drives cfg_start_i so that the block samples both on the same clock edge. The coincident start is judged accepted when sixteen correctly framed transfers arrive in total with the table contents in order, and when the minimum select-high gap holds across the boundary. A second scenario drives a start request in the middle of a running sequence. It is judged ignored when exactly eight transfers appear and the bus stays quiet afterwards.

// File: rtl/radio_cfg_pkg.sv
package radio_cfg_pkg;

    localparam int ENTRY_W = 24;
    localparam int STAT_W  = 8;

    typedef enum logic [2:0] {
        X_IDLE, X_LEAD, X_HIGH, X_LOW, X_TAIL, X_GAP
    } xfer_state_e;

    typedef enum logic [1:0] {
        S_IDLE, S_WAIT
    } seq_state_e;

    // Setting k: address/command byte 8'h20+k, register value 16'hB400 + k*16'h0111
    function automatic logic [ENTRY_W-1:0] cfg_entry(input int unsigned k);
        logic [7:0]  a;
        logic [15:0] v;
        a = 8'(32'h20 + k);
        v = 16'(32'hB400 + k * 32'h0111);
        return {a, v};
    endfunction

endpackage

// File: rtl/cfg_rom.sv
module cfg_rom
    import radio_cfg_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [IDX_W-1:0]   idx_i,
    output logic [ENTRY_W-1:0] entry_o
);

    logic [ENTRY_W-1:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_w[g] = cfg_entry(g);
    end

    always_comb begin
        entry_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx_i == IDX_W'(i)) entry_o = table_w[i];
        end
    end

endmodule

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
    parameter int HALF_DIV = 5,
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_reg_t;

    tick_reg_t tr_d, tr_q;

    always_comb begin
        tr_d   = tr_q;
        tick_o = run_i && (tr_q.cnt == CW'(HALF_DIV - 1));
        if (!run_i || tick_o) tr_d.cnt = '0;
        else                  tr_d.cnt = tr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    // Counter never passes the terminal half-period value
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_q.cnt <= CW'(HALF_DIV - 1));

endmodule

// File: rtl/spi_word_xfer.sv
module spi_word_xfer
    import radio_cfg_pkg::*;
#(
    parameter int W         = ENTRY_W,
    parameter int SW        = STAT_W,
    parameter int GAP_TICKS = 2,
    localparam int BC_W = $clog2(W),
    localparam int GC_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [W-1:0]  word_i,
    input  logic          tick_i,
    output logic          run_o,
    output logic          idle_o,
    output logic          done_o,
    output logic [SW-1:0] rx_head_o,
    output logic          sel_n_o,
    output logic          sclk_o,
    output logic          dout_o,
    input  logic          din_i
);

    typedef struct packed {
        xfer_state_e     state;
        logic [W-1:0]    sh;
        logic [W-1:0]    rx;
        logic [BC_W-1:0] bitcnt;
        logic [GC_W-1:0] gapcnt;
        logic            sel_n;
        logic            sclk;
        logic            done;
    } xfer_reg_t;

    xfer_reg_t x_d, x_q;

    always_comb begin
        x_d      = x_q;
        x_d.done = 1'b0;
        unique case (x_q.state)
            X_IDLE: begin
                if (go_i) begin
                    x_d.sh     = word_i;
                    x_d.sel_n  = 1'b0;
                    x_d.sclk   = 1'b0;
                    x_d.bitcnt = '0;
                    x_d.state  = X_LEAD;
                end
            end
            X_LEAD, X_LOW: begin
                if (tick_i) begin
                    x_d.sclk  = 1'b1;
                    x_d.rx    = {x_q.rx[W-2:0], din_i};
                    x_d.state = X_HIGH;
                end
            end
            X_HIGH: begin
                if (tick_i) begin
                    x_d.sclk = 1'b0;
                    if (x_q.bitcnt == BC_W'(W - 1)) begin
                        x_d.state = X_TAIL;
                    end else begin
                        x_d.sh     = {x_q.sh[W-2:0], 1'b0};
                        x_d.bitcnt = x_q.bitcnt + 1'b1;
                        x_d.state  = X_LOW;
                    end
                end
            end
            X_TAIL: begin
                if (tick_i) begin
                    x_d.sel_n  = 1'b1;
                    x_d.gapcnt = '0;
                    x_d.state  = X_GAP;
                end
            end
            X_GAP: begin
                if (tick_i) begin
                    if (x_q.gapcnt == GC_W'(GAP_TICKS - 1)) begin
                        x_d.state = X_IDLE;
                        x_d.done  = 1'b1;
                    end else begin
                        x_d.gapcnt = x_q.gapcnt + 1'b1;
                    end
                end
            end
            default: x_d.state = X_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q.state  <= X_IDLE;
            x_q.sh     <= '0;
            x_q.rx     <= '0;
            x_q.bitcnt <= '0;
            x_q.gapcnt <= '0;
            x_q.sel_n  <= 1'b1;
            x_q.sclk   <= 1'b0;
            x_q.done   <= 1'b0;
        end else begin
            x_q <= x_d;
        end
    end

    assign run_o     = (x_q.state != X_IDLE);
    assign idle_o    = (x_q.state == X_IDLE);
    assign done_o    = x_q.done;
    assign rx_head_o = x_q.rx[W-1 -: SW];
    assign sel_n_o   = x_q.sel_n;
    assign sclk_o    = x_q.sclk;
    assign dout_o    = x_q.sh[W-1];

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_q.sel_n |-> !x_q.sclk);

    // R5
    dout_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.sclk && $past(x_q.sclk)) |-> $stable(x_q.sh[W-1]));

    // R6
    gap_sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.state == X_GAP) |-> x_q.sel_n);

endmodule

// File: rtl/radio_cfg_seq.sv
module radio_cfg_seq
    import radio_cfg_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int HALF_DIV  = 5,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start_i,
    output logic              cfg_done_o,
    output logic [STAT_W-1:0] radio_status_o,
    output logic              bus_sel_n_o,
    output logic              bus_clk_o,
    output logic              bus_dout_o,
    input  logic              bus_din_i
);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic              go;
        logic              done;
        logic [STAT_W-1:0] status;
    } seq_reg_t;

    seq_reg_t s_d, s_q;

    logic [ENTRY_W-1:0] entry_w;
    logic               tick_w;
    logic               run_w;
    logic               xidle_w;
    logic               xdone_w;
    logic [STAT_W-1:0]  head_w;

    cfg_rom #(.DEPTH(N_ENTRIES)) u_rom (
        .idx_i  (s_q.idx),
        .entry_o(entry_w)
    );

    sclk_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run_w),
        .tick_o(tick_w)
    );

    spi_word_xfer #(.W(ENTRY_W), .SW(STAT_W), .GAP_TICKS(2)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (s_q.go),
        .word_i   (entry_w),
        .tick_i   (tick_w),
        .run_o    (run_w),
        .idle_o   (xidle_w),
        .done_o   (xdone_w),
        .rx_head_o(head_w),
        .sel_n_o  (bus_sel_n_o),
        .sclk_o   (bus_clk_o),
        .dout_o   (bus_dout_o),
        .din_i    (bus_din_i)
    );

    always_comb begin
        s_d      = s_q;
        s_d.go   = 1'b0;
        s_d.done = 1'b0;
        unique case (s_q.state)
            S_IDLE: begin
                if (cfg_start_i) begin
                    s_d.idx   = '0;
                    s_d.go    = 1'b1;
                    s_d.state = S_WAIT;
                end
            end
            S_WAIT: begin
                if (xdone_w) begin
                    s_d.status = head_w;
                    if (s_q.idx == IDX_W'(N_ENTRIES - 1)) begin
                        s_d.done  = 1'b1;
                        s_d.state = S_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.go  = 1'b1;
                    end
                end
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state  <= S_IDLE;
            s_q.idx    <= '0;
            s_q.go     <= 1'b0;
            s_q.done   <= 1'b0;
            s_q.status <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_done_o     = s_q.done;
    assign radio_status_o = s_q.status;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R8
    done_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (bus_sel_n_o && xidle_w));

    // R2
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.go |-> xidle_w);

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xdone_w |=> $stable(s_q.status));

endmodule

// File: tb/tb_radio_cfg_seq.sv
`timescale 1ns/1ps
module tb_radio_cfg_seq;

    localparam int HALF   = 5;
    localparam int NENT   = 8;
    localparam int PER_NS = 2 * HALF * 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic       done;
    logic [7:0] status;
    logic       sel_n, sclk, dout;
    logic       din = 1'b0;

    always #5 clk = ~clk;

    radio_cfg_seq #(.N_ENTRIES(NENT), .HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_start_i(start), .cfg_done_o(done),
        .radio_status_o(status), .bus_sel_n_o(sel_n), .bus_clk_o(sclk),
        .bus_dout_o(dout), .bus_din_i(din)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- radio model ----------------
    logic [23:0] rx_word [32];
    int          rx_bits [32];
    int          fr_total = 0;
    bit          in_frame = 0;
    logic [23:0] tx_sh, cur_rx;
    int          cur_bits;
    time         t_rise_last, t_sel_up;
    bit          have_sel_up = 0;
    int          bad_period = 0, bad_gap = 0, bad_idle = 0, bad_dout = 0;

    function automatic logic [7:0] stat_of(input int f);
        return 8'(8'h80 + f);
    endfunction

    always @(negedge sel_n) begin
        if (have_sel_up && ($time - t_sel_up) < PER_NS) bad_gap++;
        in_frame = 1;
        cur_bits = 0;
        cur_rx   = '0;
        tx_sh    = {stat_of(fr_total), 16'h5AA5};
        din     <= tx_sh[23];
    end

    always @(posedge sel_n) begin
        if (in_frame) begin
            rx_word[fr_total % 32] = cur_rx;
            rx_bits[fr_total % 32] = cur_bits;
            fr_total++;
            in_frame    = 0;
            t_sel_up    = $time;
            have_sel_up = 1;
        end
    end

    always @(posedge sclk) begin
        if (sel_n) bad_idle++;
        else begin
            if (cur_bits > 0 && ($time - t_rise_last) != PER_NS) bad_period++;
            t_rise_last = $time;
            cur_rx = {cur_rx[22:0], dout};
            cur_bits++;
        end
    end

    always @(negedge sclk) begin
        if (!sel_n) begin
            tx_sh = {tx_sh[22:0], 1'b0};
            din  <= tx_sh[23];
        end
    end

    always @(dout) begin
        #1;
        if (!sel_n && sclk) bad_dout++;
    end

    // ---------------- helpers ----------------
    function automatic logic [23:0] exp_word(input int k);
        logic [7:0]  a;
        logic [15:0] v;
        a = 8'h20 + 8'(k);
        v = 16'hB400 + 16'(k) * 16'h0111;
        return {a, v};
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
    endtask

    task automatic check_frames(input int base, input int cnt, input int k0);
        for (int i = 0; i < cnt; i++) begin
            check(rx_bits[(base + i) % 32] == 24, "R2 bits per transfer",
                  rx_bits[(base + i) % 32], 24);
            check(rx_word[(base + i) % 32] == exp_word((k0 + i) % NENT), "R3 transfer word",
                  rx_word[(base + i) % 32], exp_word((k0 + i) % NENT));
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(sel_n == 1'b1 && sclk == 1'b0, "R1 bus idle in reset", {sel_n, sclk}, 2'b10);
        check(done == 1'b0 && status == 8'h00, "R1 done/status in reset", {done, status}, 9'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sel_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1 idle after release",
              {sel_n, sclk, done}, 3'b100);
    endtask

    task automatic t_single_run();
        int base;
        bit seen;
        base = fr_total;
        pulse_start();
        wait_done(seen);
        check(seen, "R8 done reached", seen, 1);
        check(sel_n == 1'b1, "R8 select high at done", sel_n, 1);
        check(fr_total - base == NENT, "R2 transfer count", fr_total - base, NENT);
        check_frames(base, NENT, 0);
        check(status == stat_of(base + NENT - 1), "R7 last status byte", status,
              stat_of(base + NENT - 1));
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
    endtask

    task automatic t_busy_start();
        int base;
        bit seen;
        base = fr_total;
        pulse_start();
        repeat (900) @(negedge clk);
        pulse_start();
        wait_done(seen);
        check(seen, "R9 done reached", seen, 1);
        repeat (500) @(negedge clk);
        check(fr_total - base == NENT, "R9 busy start ignored", fr_total - base, NENT);
        check_frames(base, NENT, 0);
    endtask

    task automatic t_start_at_done();
        int base;
        bit seen;
        base = fr_total;
        pulse_start();
        wait_done(seen);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check(seen, "R10 second done reached", seen, 1);
        check(fr_total - base == 2 * NENT, "R10 start with done accepted",
              fr_total - base, 2 * NENT);
        check_frames(base, 2 * NENT, 0);
        check(status == stat_of(base + 2 * NENT - 1), "R7 status after second run", status,
              stat_of(base + 2 * NENT - 1));
    endtask

    task automatic t_timing();
        check(bad_period == 0, "R4 serial clock period", bad_period, 0);
        check(bad_idle == 0, "R4 clock low while deselected", bad_idle, 0);
        check(bad_dout == 0, "R5 data changes with clock low", bad_dout, 0);
        check(bad_gap == 0, "R6 select gap", bad_gap, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_single_run();
        t_busy_start();
        t_start_at_done();
        t_timing();
        summary();
    end

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule